// File: doc/BRIEF.md
# Open-Drain Multi-Master Line Arbiter

This block sits between a master-mode bit sequencer and the two open-drain pads of a two-wire serial bus. The sequencer states the level it wants on the data line and on the clock line, whether it is currently acting as master, and whether the byte in flight is an address byte or a data byte. The block turns the wanted levels into pull-down enables. A line is never driven high: a one is sent by letting go of the line, and a zero by switching on the low driver.

Because other masters may share the bus, the block watches the data line while this device sends a one. The check is made on each rising edge of the clock line as seen on the bus, after input synchronisation. It is not made when the sequencer releases its own clock, because another device may still be holding the clock low. If the data line reads low where a one was sent, arbitration is lost. Both pull-downs are dropped and stay dropped, and the block records the stage in which the loss happened. After a loss in the address stage, the receive path should keep listening, since this device may itself be addressed. After a loss in the data stage, the byte must be sent again later. The lost flag holds until a new Start condition is seen or software clears it.

Top module: `mm_line_arbiter`

## Requirements
- R1: `sda_oe` is 1 (line pulled low) only while `tx_active`=1, `sda_want`=0 and `lost`=0; `scl_oe` follows the same rule with `scl_want`. With `tx_active`=0 both enables are 0. No output ever drives a line high.
- R2: While `tx_active`=1 and `sda_want`=1, a rising edge of the synchronised bus clock that finds the synchronised data line low sets `lost`. With `tx_active`=0, no bus activity sets `lost`.
- R3: A rising clock edge with `sda_want`=0 never sets `lost`, even though the data line is low.
- R4: The data line is compared only at the bus clock rising edge. The data line falling while the clock stays high does not set `lost`. A low data line while the sequencer has released the clock and another device holds it low does not set `lost` until the clock actually rises.
- R5: `lost` rises no later than SYNC_STAGES+1 clock edges after the bus clock line rises. From then on, `sda_oe` and `scl_oe` stay 0 whatever the sequencer requests.
- R6: When `lost` rises, `lost_in_data` takes the value `stage_data` had at the comparing edge (0 = address byte, 1 = data byte).
- R7: While `lost`=1, `retry_req` is 1 exactly when the loss was in a data byte, and `slave_keep` is 1 exactly when it was in an address byte. Both are 0 while `lost`=0.
- R8: `lost` stays set until a clock edge with `bus_start`=1 or `clr_lost`=1. A clear on the same edge as a new loss takes precedence.
- R9: After reset, `sda_oe`, `scl_oe`, `lost`, `lost_in_data`, `retry_req` and `slave_keep` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_active | input | 1 | Sequencer is acting as bus master |
| sda_want | input | 1 | Wanted data line level (1 = release) |
| scl_want | input | 1 | Wanted clock line level (1 = release) |
| stage_data | input | 1 | Byte in flight: 0 address, 1 data |
| bus_start | input | 1 | Pulse: Start condition detected on the bus |
| clr_lost | input | 1 | Pulse: software clear of the lost flag |
| sda_in | input | 1 | Data line level read from the pad |
| scl_in | input | 1 | Clock line level read from the pad |
| sda_oe | output | 1 | Data line pull-down enable |
| scl_oe | output | 1 | Clock line pull-down enable |
| lost | output | 1 | Sticky arbitration-lost flag |
| lost_in_data | output | 1 | Stage of the recorded loss: 0 address, 1 data |
| retry_req | output | 1 | Data byte must be resent |
| slave_keep | output | 1 | Receive path should keep listening |

## Verification
The bench models the wired-AND bus with a second master that can hold either line low. It targets the cases that break naive comparators. A design that compared while sending a zero would report a loss on every ordinary zero bit. A design that sampled on its own clock release instead of the bus edge would lose arbitration while another master is stretching the clock. A design that sampled the data line at any time while the clock is high would mistake a Start-like data transition for a loss. The bench also checks that the enables stay off after a loss even when the sequencer asks for zeros, that the recorded stage routes to the retry or listen output, and that a clear held across the comparing edge wins.

// File: rtl/mm_line_arbiter.sv
`timescale 1ns/1ps
module mm_line_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic sda_want,
  input  logic scl_want,
  input  logic stage_data,
  input  logic bus_start,
  input  logic clr_lost,
  input  logic sda_in,
  input  logic scl_in,
  output logic sda_oe,
  output logic scl_oe,
  output logic lost,
  output logic lost_in_data,
  output logic retry_req,
  output logic slave_keep
);
  localparam int SW = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [SW-1:0] sda_sh, scl_sh;
  logic scl_prev, lost_q, stage_q;

  wire sda_s    = sda_sh[SW-1];
  wire scl_s    = scl_sh[SW-1];
  wire scl_rise = scl_s & ~scl_prev;
  wire clear    = bus_start | clr_lost;
  wire lose_now = tx_active & sda_want & ~lost_q & scl_rise & ~sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sh   <= '1;
      scl_sh   <= '1;
      scl_prev <= 1'b1;
    end else begin
      sda_sh[0] <= sda_in;
      scl_sh[0] <= scl_in;
      for (int i = 1; i < SW; i++) begin
        sda_sh[i] <= sda_sh[i-1];
        scl_sh[i] <= scl_sh[i-1];
      end
      scl_prev <= scl_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q  <= 1'b0;
      stage_q <= 1'b0;
    end else if (clear) begin
      lost_q  <= 1'b0;
      stage_q <= 1'b0;
    end else if (lose_now) begin
      lost_q  <= 1'b1;
      stage_q <= stage_data;
    end
  end

  assign sda_oe       = tx_active & ~lost_q & ~sda_want;
  assign scl_oe       = tx_active & ~lost_q & ~scl_want;
  assign lost         = lost_q;
  assign lost_in_data = stage_q;
  assign retry_req    = lost_q & stage_q;
  assign slave_keep   = lost_q & ~stage_q;
endmodule

module mm_line_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic sda_want,
  input logic stage_data,
  input logic bus_start,
  input logic clr_lost,
  input logic sda_oe,
  input logic scl_oe,
  input logic lost,
  input logic lost_in_data,
  input logic retry_req,
  input logic slave_keep
);
  a_r1_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |-> (!sda_oe && !scl_oe));

  a_r2_loss_needs_high_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> $past(tx_active && sda_want));

  a_r5_released_when_lost: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> (!sda_oe && !scl_oe));

  a_r6_stage_captured: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> (lost_in_data == $past(stage_data)));

  a_r7_outcome_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    lost |-> $onehot({retry_req, slave_keep}));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lost && !bus_start && !clr_lost) |=> lost);

  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_start || clr_lost) |=> !lost);
endmodule

bind mm_line_arbiter mm_line_arbiter_chk chk (
  .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .sda_want(sda_want),
  .stage_data(stage_data), .bus_start(bus_start), .clr_lost(clr_lost),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .lost(lost), .lost_in_data(lost_in_data),
  .retry_req(retry_req), .slave_keep(slave_keep)
);

// File: tb/mm_line_arbiter_test.sv
`timescale 1ns/1ps
module mm_line_arbiter_test;
  localparam int SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_active = 1'b0, sda_want = 1'b1, scl_want = 1'b1, stage_data = 1'b0;
  logic bus_start = 1'b0, clr_lost = 1'b0;
  logic other_sda_low = 1'b0, other_scl_low = 1'b0;
  logic sda_oe, scl_oe, lost, lost_in_data, retry_req, slave_keep;
  int errs = 0, total = 0;
  bit done = 0;

  wire sda_bus = ~(sda_oe | other_sda_low);
  wire scl_bus = ~(scl_oe | other_scl_low);

  always #4 clk = ~clk;

  mm_line_arbiter #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .sda_want(sda_want),
    .scl_want(scl_want), .stage_data(stage_data), .bus_start(bus_start),
    .clr_lost(clr_lost), .sda_in(sda_bus), .scl_in(scl_bus),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .lost(lost), .lost_in_data(lost_in_data),
    .retry_req(retry_req), .slave_keep(slave_keep));

  task automatic check(input logic got, input logic exp, input string what);
    total++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b", what, got, exp);
    end
  endtask

  task automatic wait_negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic own_clock_pulse();
    scl_want = 1'b1; wait_negs(6);
    scl_want = 1'b0; wait_negs(6);
  endtask

  task automatic clear_flag();
    clr_lost = 1'b1; wait_negs(1); clr_lost = 1'b0; wait_negs(1);
  endtask

  task automatic t_reset();
    check(sda_oe, 1'b0, "R9 sda_oe after reset");
    check(scl_oe, 1'b0, "R9 scl_oe after reset");
    check(lost, 1'b0, "R9 lost after reset");
    check(lost_in_data, 1'b0, "R9 lost_in_data after reset");
    check(retry_req, 1'b0, "R9 retry_req after reset");
    check(slave_keep, 1'b0, "R9 slave_keep after reset");
  endtask

  task automatic t_drive();
    tx_active = 1'b1; sda_want = 1'b0; scl_want = 1'b0; wait_negs(1);
    check(sda_oe, 1'b1, "R1 sda pulled for zero");
    check(scl_oe, 1'b1, "R1 scl pulled for low");
    sda_want = 1'b1; wait_negs(1);
    check(sda_oe, 1'b0, "R1 sda released for one");
    tx_active = 1'b0; sda_want = 1'b0; wait_negs(1);
    check(sda_oe, 1'b0, "R1 sda idle when inactive");
    check(scl_oe, 1'b0, "R1 scl idle when inactive");
    tx_active = 1'b1; sda_want = 1'b1; scl_want = 1'b0; wait_negs(4);
  endtask

  task automatic t_match();
    sda_want = 1'b1; own_clock_pulse();
    check(lost, 1'b0, "R2 no loss when line matches");
  endtask

  task automatic t_zero_bit();
    sda_want = 1'b0; other_sda_low = 1'b1; own_clock_pulse();
    check(lost, 1'b0, "R3 no compare on zero bit");
    other_sda_low = 1'b0; sda_want = 1'b1; wait_negs(4);
  endtask

  task automatic t_sda_after_rise();
    sda_want = 1'b1; scl_want = 1'b1; wait_negs(6);
    other_sda_low = 1'b1; wait_negs(6);
    check(lost, 1'b0, "R4 data fall with clock high ignored");
    scl_want = 1'b0; wait_negs(4);
    other_sda_low = 1'b0; wait_negs(4);
  endtask

  task automatic t_stretch_addr_loss();
    stage_data = 1'b0; sda_want = 1'b1;
    other_scl_low = 1'b1; wait_negs(2);
    other_sda_low = 1'b1; scl_want = 1'b1; wait_negs(8);
    check(lost, 1'b0, "R4 no compare while clock held by other device");
    other_scl_low = 1'b0; wait_negs(SYNC + 1);
    check(lost, 1'b1, "R2 loss at bus clock rise");
    check(sda_oe, 1'b0, "R5 sda released on loss");
    check(scl_oe, 1'b0, "R5 scl released on loss");
    check(lost_in_data, 1'b0, "R6 stage address recorded");
    check(slave_keep, 1'b1, "R7 keep listening after address loss");
    check(retry_req, 1'b0, "R7 no retry after address loss");
    other_sda_low = 1'b0; sda_want = 1'b0; scl_want = 1'b0; wait_negs(10);
    check(sda_oe, 1'b0, "R5 sda stays released while lost");
    check(scl_oe, 1'b0, "R5 scl stays released while lost");
    check(lost, 1'b1, "R8 lost is sticky");
    clear_flag();
    check(lost, 1'b0, "R8 software clear");
    check(slave_keep, 1'b0, "R7 slave_keep drops with lost");
    check(scl_oe, 1'b1, "R1 drive resumes after clear");
    sda_want = 1'b1; wait_negs(4);
  endtask

  task automatic t_data_loss();
    stage_data = 1'b1; sda_want = 1'b1; other_sda_low = 1'b1;
    own_clock_pulse();
    check(lost, 1'b1, "R2 loss in data byte");
    check(lost_in_data, 1'b1, "R6 stage data recorded");
    check(retry_req, 1'b1, "R7 retry after data loss");
    check(slave_keep, 1'b0, "R7 no listen after data loss");
    other_sda_low = 1'b0;
    bus_start = 1'b1; wait_negs(1); bus_start = 1'b0; wait_negs(1);
    check(lost, 1'b0, "R8 start clears lost");
    check(retry_req, 1'b0, "R7 retry drops with lost");
    stage_data = 1'b0;
  endtask

  task automatic t_clear_priority();
    sda_want = 1'b1; other_sda_low = 1'b1; clr_lost = 1'b1;
    own_clock_pulse();
    clr_lost = 1'b0; wait_negs(2);
    check(lost, 1'b0, "R8 clear wins over loss");
    other_sda_low = 1'b0; wait_negs(2);
  endtask

  task automatic t_inactive();
    tx_active = 1'b0; sda_want = 1'b1; other_sda_low = 1'b1;
    other_scl_low = 1'b1; wait_negs(6);
    other_scl_low = 1'b0; wait_negs(6);
    check(lost, 1'b0, "R2 no loss while not master");
    other_sda_low = 1'b0; wait_negs(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    wait_negs(3);
    rst_n = 1'b1;
    wait_negs(1);
    t_reset();
    t_drive();
    t_match();
    t_zero_bit();
    t_sda_after_rise();
    t_stretch_addr_loss();
    t_data_loss();
    t_clear_priority();
    t_inactive();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule